// File: doc/BRIEF.md
# Strobed Parallel Port Controller

The block is a host-programmed controller for 24 parallel I/O lines. These lines form two 8-bit data ports, A and B, and an 8-bit port C. A host reaches four byte-wide locations over a simple register bus, one location for each port and one control location. Writing a mode word to the control location does three things: it chooses basic or strobed transfer for group A (port A plus the upper half of port C) and for group B (port B plus the lower half of port C), it sets the direction of every port, and it returns all handshake state to idle.

In basic transfer, every port is a plain input or output port. In strobed transfer, fixed lines of port C become handshake lines:

- For an input port, an external device pulls a strobe line low. The port latches the data and raises a buffer-full line. When the strobe returns high, the port can raise an interrupt request.
- For an output port, a host write pulls an active-low output-buffer-full line low. The external device then pulses an acknowledge line. The rising edge of that acknowledge releases the buffer-full line and can raise the interrupt request.

Each interrupt request is gated by an enable bit. The host sets or clears that enable with the single-bit form of the control word. When the host reads port C, the handshake lines and enable bits show up in their bit positions as status.

Port pins are split into input value, output value and output-enable vectors, so the block needs no tristate pins.

Top module: `pport_ctrl`

## Requirements
- R1: After synchronous reset, all three ports are basic inputs (all `*_oe` low), every output latch is 0x00, all handshake flags and interrupt enables are inactive, and `irq_a`/`irq_b` are low.
- R2: A write with `wdata[7]=1` to address 3 is a mode word, and its fields take effect from the next cycle:
  - group A is strobed when bit 6 or bit 5 is set;
  - bit 4 = 1 makes port A an input;
  - bit 3 = 1 makes PC7..PC4 inputs;
  - bit 2 = 1 makes group B strobed;
  - bit 1 = 1 makes port B an input;
  - bit 0 = 1 makes PC3..PC0 inputs.
  In basic transfer, an output port drives its latch and a read of an input port returns its live pins.
- R3: A write with `wdata[7]=0` to address 3 sets bit `wdata[3:1]` of the port C output latch to `wdata[0]`. No other bit of the latch changes.
- R4: Any mode word clears the A, B and C output latches to 0x00. It also returns every buffer-full flag, interrupt request and interrupt enable to its inactive level: input buffer-full low, output buffer-full (active low) high.
- R5: In strobed input, each cycle the strobe line is low the port data is captured and the input buffer-full line goes high the next cycle. A read of the port returns the captured byte, not the live pins. Strobe and buffer-full lines: port A uses PC4 and PC5, port B uses PC2 and PC1.
- R6: In strobed input, a strobe rising edge while buffer-full is high and the enable is set raises the interrupt request (port A on PC3, port B on PC0) the next cycle. A host read of that port clears both buffer-full and the request the next cycle.
- R7: In strobed output, a host write to the port updates the driven data and clears the interrupt request, and drives the active-low buffer-full line low the next cycle. That line is PC7 for port A and PC1 for port B.
- R8: In strobed output, a rising edge on the acknowledge line drives the buffer-full line high again the next cycle. If the enable is set, it also raises the interrupt request. The acknowledge line is PC6 for port A and PC2 for port B.
- R9: An interrupt request is seen on `irq_*` and on its port C line only while its enable is set. The enable is written through the single-bit control word at the strobe or acknowledge bit number of its port: 4 for port A input, 6 for port A output, 2 for port B. Clearing the enable removes a pending request from the outputs the next cycle.
- R10: A read of port C returns the driven value for output bits and the pin value for input bits. In strobed groups, the interrupt enable bit replaces the strobe or acknowledge bit position.
- R11: Group B strobed transfer follows R5 to R8 on the port B lines and is independent of group A.
- R12: Address 0 selects port A, 1 port B, 2 port C and 3 the control location. Reads of address 3 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| rd_en | input | 1 | Host read strobe, one cycle per read |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, valid in the cycle of the read |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A drive values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B drive values |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin values, including strobe and acknowledge |
| pc_out | output | 8 | Port C drive values, including handshake lines |
| pc_oe | output | 8 | Port C output enables |
| irq_a | output | 1 | Port A interrupt request |
| irq_b | output | 1 | Port B interrupt request |

## Verification
Read data is combinational, so it is due in the same cycle as `rd_en`. Every latch, flag, enable and request is registered. Its effect shows one cycle after the write, read or low strobe, and one cycle after the first high sample of a strobe or acknowledge edge. The bench drives inputs on the falling edge and samples a few nanoseconds later. Directed checks are placed at exactly those cycle offsets. A behavioural model is also stepped on every rising edge and compared with all outputs after each falling edge, so a result that arrives early or late is caught in the cycle it goes wrong.

// File: rtl/pport_pkg.sv
package pport_pkg;

    localparam int DW = 8;
    localparam int AW = 2;
    localparam int NGRP = 2;

    typedef enum logic [AW-1:0] {
        SEL_A   = 2'd0,
        SEL_B   = 2'd1,
        SEL_C   = 2'd2,
        SEL_CTL = 2'd3
    } reg_sel_e;

    // Stored mode word, bit 6 down to bit 0 of the written byte.
    typedef struct packed {
        logic a_alt;
        logic a_strobed;
        logic a_is_in;
        logic cu_is_in;
        logic b_strobed;
        logic b_is_in;
        logic cl_is_in;
    } ctl_t;

    localparam ctl_t CTL_RESET = 7'h1B;

    // Handshake state of one group.
    typedef struct packed {
        logic full;
        logic intr;
        logic inte;
    } hs_t;

    // Fixed port C line numbers used by strobed groups.
    localparam logic [2:0] A_STB_LINE = 3'd4;
    localparam logic [2:0] A_ACK_LINE = 3'd6;
    localparam logic [2:0] B_HS_LINE  = 3'd2;

    function automatic logic grp_a_strobed(ctl_t c);
        return c.a_alt | c.a_strobed;
    endfunction

    function automatic logic [2:0] a_enable_line(logic is_in);
        return is_in ? A_STB_LINE : A_ACK_LINE;
    endfunction

endpackage

// File: rtl/pport_cfg.sv
module pport_cfg
    import pport_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  reg_sel_e      sel,
    input  logic [DW-1:0] wdata,
    output ctl_t          cfg,
    output logic          mode_set,
    output logic          bit_op,
    output logic [2:0]    bit_idx,
    output logic          bit_val
);

    always_comb begin
        mode_set = wr_en && (sel == SEL_CTL) && wdata[DW-1];
        bit_op   = wr_en && (sel == SEL_CTL) && !wdata[DW-1];
        bit_idx  = wdata[3:1];
        bit_val  = wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= CTL_RESET;
        else if (mode_set)
            cfg <= ctl_t'(wdata[DW-2:0]);
    end

    // R2: a mode word is held from the next cycle on
    p_mode_load_r2: assert property (@(posedge clk) disable iff (rst)
        mode_set |=> (cfg == $past(wdata[DW-2:0])));

endmodule

// File: rtl/pport_hs_chan.sv
module pport_hs_chan
    import pport_pkg::*;
#(
    parameter int WIDTH = DW
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_set,
    input  logic             strobed,
    input  logic             is_in,
    input  logic             line_n,
    input  logic             line_rise,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic             inte_wr,
    input  logic             inte_val,
    input  logic [WIDTH-1:0] din,
    output hs_t              st,
    output logic             irq,
    output logic [WIDTH-1:0] held
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '0;
            held <= '0;
        end else if (mode_set) begin
            st <= '0;
        end else begin
            if (inte_wr)
                st.inte <= inte_val;
            if (strobed) begin
                if (is_in) begin
                    if (!line_n) begin
                        held    <= din;
                        st.full <= 1'b1;
                    end else if (host_rd) begin
                        st.full <= 1'b0;
                    end
                    if (line_rise && st.full && st.inte)
                        st.intr <= 1'b1;
                    else if (host_rd)
                        st.intr <= 1'b0;
                end else begin
                    if (host_wr) begin
                        st.full <= 1'b1;
                        st.intr <= 1'b0;
                    end else if (line_rise) begin
                        st.full <= 1'b0;
                        if (st.inte)
                            st.intr <= 1'b1;
                    end
                end
            end
        end
    end

    assign irq = st.intr & st.inte;

    // R4: a mode word leaves every flag idle
    p_mode_idle_r4: assert property (@(posedge clk) disable iff (rst)
        mode_set |=> (!st.full && !st.intr && !st.inte));

    // R5: a low strobe fills the input buffer
    p_strobe_fill_r5: assert property (@(posedge clk) disable iff (rst)
        (strobed && is_in && !line_n && !mode_set) |=> st.full);

    // R6: a host read empties the input buffer
    p_read_empty_r6: assert property (@(posedge clk) disable iff (rst)
        (strobed && is_in && host_rd && line_n && !mode_set) |=> (!st.full && !st.intr));

    // R7: a host write fills the output buffer and drops the request
    p_write_fill_r7: assert property (@(posedge clk) disable iff (rst)
        (strobed && !is_in && host_wr && !mode_set) |=> (st.full && !st.intr));

    // R8: an acknowledge edge empties the output buffer
    p_ack_empty_r8: assert property (@(posedge clk) disable iff (rst)
        (strobed && !is_in && line_rise && !host_wr && !mode_set) |=> !st.full);

    // R9: a request only rises while its enable is set
    p_req_gated_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(st.intr) |-> $past(st.inte));

endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
    import pport_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_oe,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_oe,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] pc_oe,
    output logic          irq_a,
    output logic          irq_b
);

    reg_sel_e        sel;
    ctl_t            cfg;
    logic            mode_set, bit_op, bit_val;
    logic [2:0]      bit_idx;
    logic [DW-1:0]   lat_a, lat_b, lat_c;
    logic [2:0]      line_prev;   // previous PC6, PC4, PC2
    logic            a_str;

    logic [NGRP-1:0] g_str, g_in, g_line, g_rise, g_wr, g_rd, g_iwr;
    logic [DW-1:0]   g_din  [NGRP];
    logic [DW-1:0]   g_held [NGRP];
    hs_t             g_st   [NGRP];
    logic [NGRP-1:0] g_irq;
    logic [DW-1:0]   c_stat;

    assign sel   = reg_sel_e'(addr);
    assign a_str = grp_a_strobed(cfg);

    pport_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .sel      (sel),
        .wdata    (wdata),
        .cfg      (cfg),
        .mode_set (mode_set),
        .bit_op   (bit_op),
        .bit_idx  (bit_idx),
        .bit_val  (bit_val)
    );

    // Output latches for the three ports
    always_ff @(posedge clk) begin
        if (rst || mode_set) begin
            lat_a <= '0;
            lat_b <= '0;
            lat_c <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_A:   lat_a <= wdata;
                SEL_B:   lat_b <= wdata;
                SEL_C:   lat_c <= wdata;
                default: if (bit_op) lat_c[bit_idx] <= bit_val;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            line_prev <= 3'b111;
        else
            line_prev <= {pc_in[A_ACK_LINE], pc_in[A_STB_LINE], pc_in[B_HS_LINE]};
    end

    // Per-group handshake hookup
    always_comb begin
        g_str[0]  = a_str;
        g_in[0]   = cfg.a_is_in;
        g_line[0] = cfg.a_is_in ? pc_in[A_STB_LINE] : pc_in[A_ACK_LINE];
        g_rise[0] = g_line[0] && !(cfg.a_is_in ? line_prev[1] : line_prev[2]);
        g_wr[0]   = wr_en && (sel == SEL_A);
        g_rd[0]   = rd_en && (sel == SEL_A);
        g_iwr[0]  = bit_op && a_str && (bit_idx == a_enable_line(cfg.a_is_in));
        g_din[0]  = pa_in;

        g_str[1]  = cfg.b_strobed;
        g_in[1]   = cfg.b_is_in;
        g_line[1] = pc_in[B_HS_LINE];
        g_rise[1] = g_line[1] && !line_prev[0];
        g_wr[1]   = wr_en && (sel == SEL_B);
        g_rd[1]   = rd_en && (sel == SEL_B);
        g_iwr[1]  = bit_op && cfg.b_strobed && (bit_idx == B_HS_LINE);
        g_din[1]  = pb_in;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        pport_hs_chan #(.WIDTH(DW)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .mode_set  (mode_set),
            .strobed   (g_str[g]),
            .is_in     (g_in[g]),
            .line_n    (g_line[g]),
            .line_rise (g_rise[g]),
            .host_wr   (g_wr[g]),
            .host_rd   (g_rd[g]),
            .inte_wr   (g_iwr[g]),
            .inte_val  (bit_val),
            .din       (g_din[g]),
            .st        (g_st[g]),
            .irq       (g_irq[g]),
            .held      (g_held[g])
        );
    end

    // Port C drive, handshake overrides and status view
    always_comb begin
        pc_oe  = {{(DW/2){~cfg.cu_is_in}}, {(DW/2){~cfg.cl_is_in}}};
        pc_out = lat_c;
        if (a_str) begin
            if (cfg.a_is_in) begin
                pc_oe[5]  = 1'b1;
                pc_out[5] = g_st[0].full;
                pc_oe[4]  = 1'b0;
            end else begin
                pc_oe[7]  = 1'b1;
                pc_out[7] = ~g_st[0].full;
                pc_oe[6]  = 1'b0;
            end
            pc_oe[3]  = 1'b1;
            pc_out[3] = g_irq[0];
        end
        if (cfg.b_strobed) begin
            pc_oe[2]  = 1'b0;
            pc_oe[1]  = 1'b1;
            pc_out[1] = cfg.b_is_in ? g_st[1].full : ~g_st[1].full;
            pc_oe[0]  = 1'b1;
            pc_out[0] = g_irq[1];
        end
        c_stat = (pc_oe & pc_out) | (~pc_oe & pc_in);
        if (a_str)
            c_stat[a_enable_line(cfg.a_is_in)] = g_st[0].inte;
        if (cfg.b_strobed)
            c_stat[B_HS_LINE] = g_st[1].inte;
    end

    always_comb begin
        case (sel)
            SEL_A:   rdata = cfg.a_is_in ? (a_str ? g_held[0] : pa_in) : lat_a;
            SEL_B:   rdata = cfg.b_is_in ? (cfg.b_strobed ? g_held[1] : pb_in) : lat_b;
            SEL_C:   rdata = c_stat;
            default: rdata = '0;
        endcase
    end

    assign pa_out = lat_a;
    assign pa_oe  = {DW{~cfg.a_is_in}};
    assign pb_out = lat_b;
    assign pb_oe  = {DW{~cfg.b_is_in}};
    assign irq_a  = g_irq[0];
    assign irq_b  = g_irq[1];

    // R3: a single-bit word lands in the port C latch
    p_bit_op_r3: assert property (@(posedge clk) disable iff (rst)
        bit_op |=> (lat_c[$past(bit_idx)] == $past(bit_val)));

    // R4: a mode word clears the data latches
    p_latch_clear_r4: assert property (@(posedge clk) disable iff (rst)
        mode_set |=> (lat_a == '0 && lat_b == '0 && lat_c == '0));

    // R12: the control location reads as zero
    p_ctl_read_r12: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_CTL) |-> (rdata == '0));

endmodule

// File: tb/pport_ctrl_tb.sv
module pport_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] addr;
    logic       wr_en, rd_en;
    logic [7:0] wdata, rdata;
    logic [7:0] pa_in, pa_out, pa_oe, pb_in, pb_out, pb_oe, pc_in, pc_out, pc_oe;
    logic       irq_a, irq_b;

    always #5 clk = ~clk;

    pport_ctrl u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";

    // ---------------- behavioural reference model ----------------
    bit [7:0] m_ctl, m_la, m_lb, m_lc, m_ina, m_inb, m_prev;
    bit       m_fa, m_fb, m_ia, m_ib, m_ea, m_eb;

    task automatic hs_step(input bit str, input bit isin, input bit s_n, input bit rise,
                           input bit hw, input bit hr, input bit [7:0] din, input bit en,
                           inout bit f, inout bit it, inout bit [7:0] h);
        bit f0;
        f0 = f;
        if (!str) return;
        if (isin) begin
            if (!s_n) begin h = din; f = 1'b1; end
            else if (hr) f = 1'b0;
            if (rise && f0 && en) it = 1'b1;
            else if (hr) it = 1'b0;
        end else begin
            if (hw) begin f = 1'b1; it = 1'b0; end
            else if (rise) begin f = 1'b0; if (en) it = 1'b1; end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_ctl = 8'h9B; m_la = 0; m_lb = 0; m_lc = 0; m_ina = 0; m_inb = 0;
            m_prev = 8'hFF; m_fa = 0; m_fb = 0; m_ia = 0; m_ib = 0; m_ea = 0; m_eb = 0;
        end else begin
            bit ms, bo, aS, sA, rA, sB, rB, na, nb;
            ms = wr_en && addr == 2'd3 && wdata[7];
            bo = wr_en && addr == 2'd3 && !wdata[7];
            aS = m_ctl[6] | m_ctl[5];
            sA = m_ctl[4] ? pc_in[4] : pc_in[6];
            rA = sA && !(m_ctl[4] ? m_prev[4] : m_prev[6]);
            sB = pc_in[2];
            rB = sB && !m_prev[2];
            if (ms) begin
                m_ctl = wdata; m_la = 0; m_lb = 0; m_lc = 0;
                m_fa = 0; m_fb = 0; m_ia = 0; m_ib = 0; m_ea = 0; m_eb = 0;
            end else begin
                na = m_ea; nb = m_eb;
                if (bo && aS && wdata[3:1] == (m_ctl[4] ? 3'd4 : 3'd6)) na = wdata[0];
                if (bo && m_ctl[2] && wdata[3:1] == 3'd2) nb = wdata[0];
                hs_step(aS, m_ctl[4], sA, rA, wr_en && addr == 2'd0, rd_en && addr == 2'd0,
                        pa_in, m_ea, m_fa, m_ia, m_ina);
                hs_step(m_ctl[2], m_ctl[1], sB, rB, wr_en && addr == 2'd1, rd_en && addr == 2'd1,
                        pb_in, m_eb, m_fb, m_ib, m_inb);
                m_ea = na; m_eb = nb;
                if (wr_en && addr == 2'd0) m_la = wdata;
                if (wr_en && addr == 2'd1) m_lb = wdata;
                if (wr_en && addr == 2'd2) m_lc = wdata;
                if (bo) m_lc[wdata[3:1]] = wdata[0];
            end
            m_prev = pc_in;
        end
    end

    task automatic model_out(output bit [7:0] pao, output bit [7:0] paoe, output bit [7:0] pbo,
                             output bit [7:0] pboe, output bit [7:0] pco, output bit [7:0] pcoe,
                             output bit [7:0] rd, output bit ia, output bit ib);
        bit aS;
        bit [7:0] st;
        aS = m_ctl[6] | m_ctl[5];
        ia = m_ia & m_ea;
        ib = m_ib & m_eb;
        paoe = m_ctl[4] ? 8'h00 : 8'hFF; pao = m_la;
        pboe = m_ctl[1] ? 8'h00 : 8'hFF; pbo = m_lb;
        pcoe = {m_ctl[3] ? 4'h0 : 4'hF, m_ctl[0] ? 4'h0 : 4'hF};
        pco  = m_lc;
        if (aS) begin
            if (m_ctl[4]) begin pcoe[5] = 1; pco[5] = m_fa; pcoe[4] = 0; end
            else begin pcoe[7] = 1; pco[7] = !m_fa; pcoe[6] = 0; end
            pcoe[3] = 1; pco[3] = ia;
        end
        if (m_ctl[2]) begin
            pcoe[2] = 0; pcoe[1] = 1; pco[1] = m_ctl[1] ? m_fb : !m_fb;
            pcoe[0] = 1; pco[0] = ib;
        end
        st = (pcoe & pco) | (~pcoe & pc_in);
        if (aS) st[m_ctl[4] ? 4 : 6] = m_ea;
        if (m_ctl[2]) st[2] = m_eb;
        case (addr)
            2'd0: rd = m_ctl[4] ? (aS ? m_ina : pa_in) : m_la;
            2'd1: rd = m_ctl[1] ? (m_ctl[2] ? m_inb : pb_in) : m_lb;
            2'd2: rd = st;
            default: rd = 8'h00;
        endcase
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            bit [7:0] pao, paoe, pbo, pboe, pco, pcoe, rd;
            bit ia, ib;
            model_out(pao, paoe, pbo, pboe, pco, pcoe, rd, ia, ib);
            checks++;
            if (pa_oe !== paoe || (pa_out & pa_oe) !== (pao & paoe) ||
                pb_oe !== pboe || (pb_out & pb_oe) !== (pbo & pboe) ||
                pc_oe !== pcoe || (pc_out & pc_oe) !== (pco & pcoe) ||
                rdata !== rd || irq_a !== ia || irq_b !== ib) begin
                fails++;
                $display("FAIL %s model compare: act pa=%h/%h pb=%h/%h pc=%h/%h rd=%h irq=%b%b exp pa=%h/%h pb=%h/%h pc=%h/%h rd=%h irq=%b%b",
                         cur_req, pa_out & pa_oe, pa_oe, pb_out & pb_oe, pb_oe, pc_out & pc_oe, pc_oe,
                         rdata, irq_a, irq_b, pao & paoe, paoe, pbo & pboe, pboe, pco & pcoe, pcoe, rd, ia, ib);
            end
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd0;
        #3;
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #3 d = rdata;
        @(negedge clk);
        rd_en = 1'b0; addr = 2'd0;
        #3;
    endtask

    task automatic line_pulse(input int b);
        @(negedge clk);
        pc_in[b] = 1'b0;
        @(negedge clk);
        pc_in[b] = 1'b1;
        #3;
    endtask

    task automatic wait_cyc();
        @(negedge clk);
        #3;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        rst = 1'b1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
        pa_in = 8'h00; pb_in = 8'h00; pc_in = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #3;
        cur_req = "R1";
        chk("R1", "pa_oe after reset", pa_oe, 8'h00);
        chk("R1", "pb_oe after reset", pb_oe, 8'h00);
        chk("R1", "pc_oe after reset", pc_oe, 8'h00);
        chk("R1", "irq after reset", {6'b0, irq_a, irq_b}, 8'h00);
        cur_req = "R12";
        host_rd(2'd3, d);
        chk("R12", "control read", d, 8'h00);

        cur_req = "R2";
        host_wr(2'd3, 8'h80);
        host_wr(2'd0, 8'h5A);
        host_wr(2'd1, 8'hC3);
        host_wr(2'd2, 8'h3C);
        chk("R2", "pa_out basic", pa_out, 8'h5A);
        chk("R2", "pa_oe basic", pa_oe, 8'hFF);
        chk("R2", "pb_out basic", pb_out, 8'hC3);
        chk("R2", "pc_out basic", pc_out, 8'h3C);
        chk("R2", "pc_oe basic", pc_oe, 8'hFF);
        host_rd(2'd0, d);
        chk("R12", "port A readback", d, 8'h5A);

        cur_req = "R4";
        host_wr(2'd3, 8'h80);
        chk("R4", "pa_out after mode word", pa_out, 8'h00);
        chk("R4", "pc_out after mode word", pc_out, 8'h00);

        cur_req = "R2";
        host_wr(2'd3, 8'h9B);
        pa_in = 8'h77; pc_in = 8'hE5;
        host_rd(2'd0, d);
        chk("R2", "port A input pins", d, 8'h77);
        host_rd(2'd2, d);
        chk("R10", "port C input pins", d, 8'hE5);
        pc_in = 8'hFF;

        cur_req = "R3";
        host_wr(2'd3, 8'h80);
        host_wr(2'd3, 8'h0B);
        chk("R3", "set PC5", pc_out, 8'h20);
        host_wr(2'd3, 8'h07);
        chk("R3", "set PC3", pc_out, 8'h28);
        host_wr(2'd3, 8'h0A);
        chk("R3", "clear PC5", pc_out, 8'h08);

        cur_req = "R5";
        host_wr(2'd3, 8'hB0);
        chk("R5", "pc_oe strobed A input", pc_oe, 8'hEF);
        host_wr(2'd3, 8'h09);
        pa_in = 8'h9E;
        line_pulse(4);
        pa_in = 8'h11;
        chk("R5", "A input buffer full", {7'b0, pc_out[5]}, 8'h01);
        chk("R6", "irq_a before rise seen", {7'b0, irq_a}, 8'h00);
        cur_req = "R6";
        wait_cyc();
        chk("R6", "irq_a after strobe rise", {7'b0, irq_a}, 8'h01);
        chk("R6", "PC3 request", {7'b0, pc_out[3]}, 8'h01);
        cur_req = "R10";
        host_rd(2'd2, d);
        chk("R10", "port C status A input", d, 8'h38);
        cur_req = "R5";
        host_rd(2'd0, d);
        chk("R5", "latched port A data", d, 8'h9E);
        chk("R6", "buffer full after read", {7'b0, pc_out[5]}, 8'h00);
        chk("R6", "irq_a after read", {7'b0, irq_a}, 8'h00);

        cur_req = "R9";
        host_wr(2'd3, 8'h08);
        line_pulse(4);
        wait_cyc();
        chk("R9", "irq_a with enable clear", {7'b0, irq_a}, 8'h00);
        chk("R9", "buffer full still set", {7'b0, pc_out[5]}, 8'h01);
        host_rd(2'd0, d);
        chk("R5", "second latched byte", d, 8'h11);

        cur_req = "R4";
        line_pulse(4);
        host_wr(2'd3, 8'hB0);
        chk("R4", "buffer full after mode word", {7'b0, pc_out[5]}, 8'h00);

        cur_req = "R7";
        host_wr(2'd3, 8'hA0);
        chk("R4", "A output buffer-full idle high", {7'b0, pc_out[7]}, 8'h01);
        host_wr(2'd3, 8'h0D);
        host_wr(2'd0, 8'h42);
        chk("R7", "pa_out strobed", pa_out, 8'h42);
        chk("R7", "A output buffer-full low", {7'b0, pc_out[7]}, 8'h00);
        cur_req = "R8";
        line_pulse(6);
        wait_cyc();
        chk("R8", "A output buffer-full released", {7'b0, pc_out[7]}, 8'h01);
        chk("R8", "irq_a after acknowledge", {7'b0, irq_a}, 8'h01);
        cur_req = "R7";
        host_wr(2'd0, 8'h43);
        chk("R7", "irq_a cleared by write", {7'b0, irq_a}, 8'h00);
        cur_req = "R9";
        line_pulse(6);
        wait_cyc();
        chk("R8", "irq_a second acknowledge", {7'b0, irq_a}, 8'h01);
        host_wr(2'd3, 8'h0C);
        chk("R9", "irq_a after enable cleared", {7'b0, irq_a}, 8'h00);
        cur_req = "R10";
        host_rd(2'd2, d);
        chk("R10", "port C status A output", d, 8'h80);

        cur_req = "R11";
        host_wr(2'd3, 8'h86);
        host_wr(2'd3, 8'h05);
        pb_in = 8'hD4;
        line_pulse(2);
        pb_in = 8'h00;
        chk("R11", "B input buffer full", {7'b0, pc_out[1]}, 8'h01);
        wait_cyc();
        chk("R11", "irq_b after strobe", {7'b0, irq_b}, 8'h01);
        chk("R11", "irq_a unaffected", {7'b0, irq_a}, 8'h00);
        host_rd(2'd1, d);
        chk("R11", "latched port B data", d, 8'hD4);
        chk("R11", "irq_b after read", {7'b0, irq_b}, 8'h00);

        host_wr(2'd3, 8'h84);
        host_wr(2'd3, 8'h05);
        host_wr(2'd1, 8'h6B);
        chk("R11", "pb_out strobed", pb_out, 8'h6B);
        chk("R11", "B output buffer-full low", {7'b0, pc_out[1]}, 8'h00);
        line_pulse(2);
        wait_cyc();
        chk("R11", "B output buffer-full released", {7'b0, pc_out[1]}, 8'h01);
        chk("R11", "irq_b after acknowledge", {7'b0, irq_b}, 8'h01);

        wait_cyc();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule